// File: doc/BRIEF.md
# Descriptor-Chained Memory Copy Engine

This block is one channel of a memory-to-memory copy engine. Software writes an eight-word transfer descriptor into the engine through a word-wide load port and then pulses `start`. The engine moves data in beats of 1, 2, 4, 16 or 32 bytes over a simple 32-bit memory port. An inner (minor) loop moves a programmed byte count, and an outer (major) loop repeats the inner loop a programmed number of times. After each beat, signed offsets step the source and destination addresses.

When the outer loop completes, the engine applies end-of-transfer address adjustments, reloads its iteration counter and reports completion. If chaining is enabled, it instead reads the next descriptor from memory. When the chained descriptor carries its go bit, the engine starts it without software help. Configuration mistakes are caught before any memory access. A memory-port error aborts the transfer and is reported with the channel's index.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset `active`, `done`, `irq_major`, `irq_half`, `err_valid`, all error flags and `mem_req` are 0.
- R2: Descriptor word k (0..7) is written with `desc_we`/`desc_idx`/`desc_wdata` only while the engine is idle; writes while `active` is 1 have no effect. Field layout: word0 source address; word1 [26:24] source size, [18:16] destination size, [15:0] signed source step; word2 byte count; word3 end source adjustment; word4 destination address; word5 [24:16] current count, [15:0] signed destination step; word6 end destination adjustment / next-descriptor address; word7 [24:16] begin count, [4] chain enable, [2] half-interrupt enable, [1] end-interrupt enable, [0] go bit.
- R3: Size code 0,1,2,4,5 selects a beat of 1,2,4,16,32 bytes. Beats of 16 and 32 bytes are moved as 4-byte accesses at ascending addresses. `mem_size` is 0/1/2 for 1/2/4 bytes.
- R4: An inner loop moves byte count / beat bytes beats. After each beat the signed steps are added to the source and destination addresses.
- R5: The last beat of the last outer iteration adds the end adjustments instead of the steps. The current count is reloaded from the begin count, `done` goes to 1 and `active` to 0, so a new `start` continues from the adjusted addresses.
- R6: On outer-loop completion with the end-interrupt enable set, `irq_major` goes to 1.
- R7: When the current count drops to half the begin count (integer halving) before completion and the half-interrupt enable is set, `irq_half` goes to 1.
- R8: With chaining enabled, completion leaves the destination address unadjusted and reads eight words from the word6 address into descriptor words 0..7, with `active` held at 1. If the loaded go bit is 1, the new descriptor runs at once and `done` returns to 0. Otherwise the engine stops with the loaded descriptor ready for `start`.
- R9: An invalid size code, unequal source and destination size codes, a source/destination address or step not aligned to the beat, or a chained next address not 4-byte aligned raises `err_off_cfg` and `err_valid` without any memory access.
- R10: A zero byte count, a count not a multiple of the beat, a zero begin count, or a current count unequal to the begin count raises `err_cnt_cfg` and `err_valid` without any memory access.
- R11: `mem_err` on a read (data or descriptor) sets `err_src_bus`, and on a write sets `err_dst_bus`. Either one ends the transfer with `active` 0, sets `err_valid` and reports parameter `CHAN_ID` on `err_chan`.
- R12: A memory request holds its address, direction and data until `mem_ack` or `mem_err`. Every access is aligned to its size, and no request is made while `active` is 0.
- R13: `start` is ignored while `active` is 1. An accepted `start` clears `done`, both interrupt flags and all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_we | input | 1 | Descriptor word write strobe |
| desc_idx | input | 3 | Descriptor word index |
| desc_wdata | input | 32 | Descriptor word value |
| start | input | 1 | Begin transfer with the loaded descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access size: 0 = 1 B, 1 = 2 B, 2 = 4 B |
| mem_wdata | output | 32 | Write data, LSB-justified |
| mem_rdata | input | 32 | Read data, LSB-justified |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed |
| active | output | 1 | Engine busy |
| done | output | 1 | Outer loop completed |
| irq_major | output | 1 | End-of-transfer interrupt flag |
| irq_half | output | 1 | Half-way interrupt flag |
| err_valid | output | 1 | Some error recorded |
| err_src_bus | output | 1 | Read access failed |
| err_dst_bus | output | 1 | Write access failed |
| err_off_cfg | output | 1 | Size, alignment or step configuration error |
| err_cnt_cfg | output | 1 | Byte count or iteration count configuration error |
| err_chan | output | CHAN_W | Channel index of the recorded error |

## Verification
Random descriptors mix every beat size, positive and negative steps, one to three inner beats and one to three outer iterations. A memory model with random response delays serves them, and a byte-exact model of the copy checks the result. Mistakes in step sign, chunk ordering or iteration counting all show up as wrong bytes. Directed cases separate the end adjustment from the step by restarting without a reload. Chaining is run with and without the go bit, which shows whether descriptors are fetched and launched. Misaligned, mismatched and miscounted descriptors, plus fault windows on read and write addresses, show whether the engine stops before or exactly at the failing access.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 9;
  localparam int STEP_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WR, ST_FETCH, ST_SGCHK
  } dma_state_t;

  // Beat size in bytes for a size code; 0 marks an unsupported code.
  function automatic logic [5:0] beat_bytes(input logic [2:0] code);
    case (code)
      3'd0:    return 6'd1;
      3'd1:    return 6'd2;
      3'd2:    return 6'd4;
      3'd4:    return 6'd16;
      3'd5:    return 6'd32;
      default: return 6'd0;
    endcase
  endfunction
endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_pkg::*;
(
  input  logic [2:0]        ssize,
  input  logic [2:0]        dsize,
  input  logic [WORD_W-1:0] saddr,
  input  logic [WORD_W-1:0] daddr,
  input  logic [STEP_W-1:0] soff,
  input  logic [STEP_W-1:0] doff,
  input  logic [WORD_W-1:0] nbytes,
  input  logic [CNT_W-1:0]  citer,
  input  logic [CNT_W-1:0]  biter,
  input  logic              chain_en,
  input  logic [WORD_W-1:0] next_addr,
  output logic              err_off,
  output logic              err_cnt
);
  logic [5:0] bb;
  logic       size_bad;
  logic [4:0] mask;

  always_comb begin
    bb       = beat_bytes(ssize);
    size_bad = (bb == 6'd0) || (ssize != dsize);
    mask     = size_bad ? 5'd0 : 5'(bb - 6'd1);
    err_off  = size_bad
             || |(saddr[4:0] & mask) || |(daddr[4:0] & mask)
             || |(soff[4:0] & mask)  || |(doff[4:0] & mask)
             || (chain_en && |next_addr[1:0]);
    err_cnt  = (nbytes == '0) || |(nbytes[4:0] & mask)
             || (biter == '0) || (citer != biter);
  end
endmodule

// File: rtl/dma_beat_plan.sv
module dma_beat_plan (
  input  logic [2:0] code,
  output logic [1:0] csize,
  output logic [2:0] last_chunk
);
  always_comb begin
    case (code)
      3'd0:    begin csize = 2'd0; last_chunk = 3'd0; end
      3'd1:    begin csize = 2'd1; last_chunk = 3'd0; end
      3'd4:    begin csize = 2'd2; last_chunk = 3'd3; end
      3'd5:    begin csize = 2'd2; last_chunk = 3'd7; end
      default: begin csize = 2'd2; last_chunk = 3'd0; end
    endcase
  end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_pkg::*;
#(
  parameter int CHAN_W  = 6,
  parameter int CHAN_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_we,
  input  logic [2:0]        desc_idx,
  input  logic [WORD_W-1:0] desc_wdata,
  input  logic              start,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              active,
  output logic              done,
  output logic              irq_major,
  output logic              irq_half,
  output logic              err_valid,
  output logic              err_src_bus,
  output logic              err_dst_bus,
  output logic              err_off_cfg,
  output logic              err_cnt_cfg,
  output logic [CHAN_W-1:0] err_chan
);
  localparam logic [CHAN_W-1:0] CID = CHAN_W'(CHAN_ID);

  dma_state_t        state;
  logic [WORD_W-1:0] saddr, daddr, nbytes, slast, dlast, left, hold, fbase;
  logic [STEP_W-1:0] soff, doff;
  logic [2:0]        ssize, dsize, chunk, fidx;
  logic [CNT_W-1:0]  citer, biter;
  logic              chain_en, ih_en, im_en, go_bit;

  logic              cfg_off, cfg_cnt;
  logic [1:0]        csize;
  logic [2:0]        last_chunk;
  logic [5:0]        bb;
  logic              fld_wr, fetch_hit, minor_end;
  logic [2:0]        wr_idx;
  logic [WORD_W-1:0] wr_data, soff_x, doff_x;

  dma_cfg_check u_cfg (
    .ssize(ssize), .dsize(dsize), .saddr(saddr), .daddr(daddr),
    .soff(soff), .doff(doff), .nbytes(nbytes), .citer(citer), .biter(biter),
    .chain_en(chain_en), .next_addr(dlast),
    .err_off(cfg_off), .err_cnt(cfg_cnt)
  );

  dma_beat_plan u_plan (.code(ssize), .csize(csize), .last_chunk(last_chunk));

  always_comb begin
    bb        = beat_bytes(ssize);
    soff_x    = {{(WORD_W-STEP_W){soff[STEP_W-1]}}, soff};
    doff_x    = {{(WORD_W-STEP_W){doff[STEP_W-1]}}, doff};
    minor_end = (left == WORD_W'(bb));
    fetch_hit = (state == ST_FETCH) && mem_ack && !mem_err;
    fld_wr    = fetch_hit || ((state == ST_IDLE) && desc_we);
    wr_idx    = fetch_hit ? fidx : desc_idx;
    wr_data   = fetch_hit ? mem_rdata : desc_wdata;
    mem_req   = (state == ST_RD) || (state == ST_WR) || (state == ST_FETCH);
    mem_we    = (state == ST_WR);
    mem_size  = (state == ST_FETCH) ? 2'd2 : csize;
    mem_wdata = hold;
    case (state)
      ST_RD:    mem_addr = saddr + (WORD_W'(chunk) << 2);
      ST_WR:    mem_addr = daddr + (WORD_W'(chunk) << 2);
      ST_FETCH: mem_addr = fbase + (WORD_W'(fidx) << 2);
      default:  mem_addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      saddr <= '0; daddr <= '0; nbytes <= '0; slast <= '0; dlast <= '0;
      left <= '0; hold <= '0; fbase <= '0; soff <= '0; doff <= '0;
      ssize <= '0; dsize <= '0; chunk <= '0; fidx <= '0;
      citer <= '0; biter <= '0;
      chain_en <= 1'b0; ih_en <= 1'b0; im_en <= 1'b0; go_bit <= 1'b0;
      active <= 1'b0; done <= 1'b0; irq_major <= 1'b0; irq_half <= 1'b0;
      err_valid <= 1'b0; err_src_bus <= 1'b0; err_dst_bus <= 1'b0;
      err_off_cfg <= 1'b0; err_cnt_cfg <= 1'b0; err_chan <= '0;
    end else begin
      if (fld_wr) begin
        case (wr_idx)
          3'd0: saddr <= wr_data;
          3'd1: begin ssize <= wr_data[26:24]; dsize <= wr_data[18:16]; soff <= wr_data[15:0]; end
          3'd2: nbytes <= wr_data;
          3'd3: slast <= wr_data;
          3'd4: daddr <= wr_data;
          3'd5: begin citer <= wr_data[24:16]; doff <= wr_data[15:0]; end
          3'd6: dlast <= wr_data;
          default: begin
            biter <= wr_data[24:16]; chain_en <= wr_data[4];
            ih_en <= wr_data[2]; im_en <= wr_data[1]; go_bit <= wr_data[0];
          end
        endcase
      end
      case (state)
        ST_IDLE: if (start) begin
          done <= 1'b0; irq_major <= 1'b0; irq_half <= 1'b0;
          err_src_bus <= 1'b0; err_dst_bus <= 1'b0;
          err_off_cfg <= cfg_off; err_cnt_cfg <= cfg_cnt;
          err_valid <= cfg_off || cfg_cnt;
          err_chan <= (cfg_off || cfg_cnt) ? CID : '0;
          if (!(cfg_off || cfg_cnt)) begin
            active <= 1'b1; left <= nbytes; chunk <= '0; state <= ST_RD;
          end
        end
        ST_RD: if (mem_err) begin
          err_valid <= 1'b1; err_src_bus <= 1'b1; err_chan <= CID;
          active <= 1'b0; chunk <= '0; state <= ST_IDLE;
        end else if (mem_ack) begin
          hold <= mem_rdata; state <= ST_WR;
        end
        ST_WR: if (mem_err) begin
          err_valid <= 1'b1; err_dst_bus <= 1'b1; err_chan <= CID;
          active <= 1'b0; chunk <= '0; state <= ST_IDLE;
        end else if (mem_ack) begin
          if (chunk != last_chunk) begin
            chunk <= chunk + 3'd1; state <= ST_RD;
          end else begin
            chunk <= '0;
            if (!minor_end) begin
              saddr <= saddr + soff_x; daddr <= daddr + doff_x;
              left <= left - WORD_W'(bb); state <= ST_RD;
            end else if (citer != CNT_W'(1)) begin
              saddr <= saddr + soff_x; daddr <= daddr + doff_x;
              citer <= citer - CNT_W'(1); left <= nbytes; state <= ST_RD;
              if (ih_en && ((citer - CNT_W'(1)) == (biter >> 1))) irq_half <= 1'b1;
            end else begin
              saddr <= saddr + slast;
              if (!chain_en) daddr <= daddr + dlast;
              citer <= biter; done <= 1'b1;
              if (im_en) irq_major <= 1'b1;
              if (chain_en) begin
                fbase <= dlast; fidx <= '0; state <= ST_FETCH;
              end else begin
                active <= 1'b0; state <= ST_IDLE;
              end
            end
          end
        end
        ST_FETCH: if (mem_err) begin
          err_valid <= 1'b1; err_src_bus <= 1'b1; err_chan <= CID;
          active <= 1'b0; state <= ST_IDLE;
        end else if (mem_ack) begin
          if (fidx == 3'd7) state <= ST_SGCHK;
          else fidx <= fidx + 3'd1;
        end
        ST_SGCHK: if (!go_bit) begin
          active <= 1'b0; state <= ST_IDLE;
        end else if (cfg_off || cfg_cnt) begin
          err_valid <= 1'b1; err_off_cfg <= cfg_off; err_cnt_cfg <= cfg_cnt;
          err_chan <= CID; active <= 1'b0; state <= ST_IDLE;
        end else begin
          done <= 1'b0; left <= nbytes; chunk <= '0; state <= ST_RD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
  parameter int CHAN_W = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic [1:0]  mem_size,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        mem_err,
  input logic        active,
  input logic        done,
  input logic        irq_major,
  input logic        err_valid
);
  // R12: a pending request keeps its address, direction and data
  a_r12_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !mem_err) |=>
      (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R12: accesses are aligned to their size
  a_r12_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((mem_size == 2'd0) || (mem_size == 2'd1 && !mem_addr[0])
                 || (mem_size == 2'd2 && mem_addr[1:0] == 2'b00)));

  // R12: no memory traffic from an idle engine
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !active |-> !mem_req);

  // R5: a newly started transfer never shows a stale completion
  a_r5_rise_clean: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> !done);

  // R6: end interrupt only together with completion
  a_r6_major_done: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_major) |-> done);

  // R11: a fresh error always leaves the engine stopped
  a_r11_err_stops: assert property (@(posedge clk) disable iff (rst)
    $rose(err_valid) |-> !active);
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.CHAN_W(CHAN_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .mem_err(mem_err), .active(active), .done(done),
  .irq_major(irq_major), .err_valid(err_valid)
);

// File: tb/dma_xfer_engine_tb.sv
module dma_xfer_engine_tb;
  localparam int CID = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        desc_we = 1'b0;
  logic [2:0]  desc_idx = '0;
  logic [31:0] desc_wdata = '0;
  logic        start = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic        active, done, irq_major, irq_half, err_valid;
  logic        err_src_bus, err_dst_bus, err_off_cfg, err_cnt_cfg;
  logic [5:0]  err_chan;

  always #4 clk = ~clk;

  dma_xfer_engine #(.CHAN_W(6), .CHAN_ID(CID)) u_dut (
    .clk(clk), .rst(rst), .desc_we(desc_we), .desc_idx(desc_idx),
    .desc_wdata(desc_wdata), .start(start), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .active(active), .done(done), .irq_major(irq_major), .irq_half(irq_half),
    .err_valid(err_valid), .err_src_bus(err_src_bus), .err_dst_bus(err_dst_bus),
    .err_off_cfg(err_off_cfg), .err_cnt_cfg(err_cnt_cfg), .err_chan(err_chan)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, hold_viol = 0, align_viol = 0;
  bit finished = 0;

  // ---------------- memory model ----------------
  logic [7:0]  mem  [0:4095];
  logic [7:0]  emem [0:4095];
  logic        pk_en = 1'b0;
  logic [11:0] pk_addr = '0;
  logic [31:0] pk_data = '0;
  logic        err_en = 1'b0;
  logic [11:0] err_lo = '0, err_hi = '0;
  logic        pend = 1'b0, pwe = 1'b0;
  logic [31:0] pa = '0;
  int          wc = 0;

  always @(posedge clk) begin : mem_model
    logic [11:0] a;
    logic [31:0] rd;
    if (rst) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 8'(i * 37 + 11);
      mem_ack <= 1'b0; mem_err <= 1'b0; pend <= 1'b0;
    end else begin
      if (pk_en) for (int i = 0; i < 4; i++) mem[12'(pk_addr + 12'(i))] <= pk_data[8*i +: 8];
      if (mem_ack || mem_err) begin
        mem_ack <= 1'b0; mem_err <= 1'b0;
      end else if (mem_req) begin
        if (!pend) begin
          pend <= 1'b1; pa <= mem_addr; pwe <= mem_we; wc <= int'($urandom % 3);
          if ((mem_size == 2'd1 && mem_addr[0]) || (mem_size == 2'd2 && mem_addr[1:0] != 0))
            align_viol++;
        end else begin
          if (mem_addr != pa || mem_we != pwe) hold_viol++;
          if (wc != 0) wc <= wc - 1;
          else begin
            pend <= 1'b0;
            a = mem_addr[11:0];
            if (err_en && a >= err_lo && a <= err_hi) mem_err <= 1'b1;
            else begin
              mem_ack <= 1'b1;
              rd = '0;
              for (int i = 0; i < (1 << mem_size); i++) begin
                if (mem_we) mem[12'(a + 12'(i))] <= mem_wdata[8*i +: 8];
                else rd[8*i +: 8] = mem[12'(a + 12'(i))];
              end
              mem_rdata <= rd;
            end
          end
        end
      end
    end
  end

  // ---------------- reporting ----------------
  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_mem(input string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < 4096; i++)
      if (mem[i] !== emem[i]) begin bad++; if (first < 0) first = i; end
    n_chk++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: byte %0h actual %0h expected %0h (%0d bad)",
               tag, first, mem[first], emem[first], bad);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [31:0] dw [0:7];

  task automatic build(input logic [31:0] sa, input logic [2:0] sc, input logic [2:0] dc,
                       input int so, input logic [31:0] nb, input logic [31:0] sl,
                       input logic [31:0] da, input int ci, input int dof,
                       input logic [31:0] dl, input int bi, input bit sg,
                       input bit ih, input bit im, input bit go);
    dw[0] = sa;
    dw[1] = {5'd0, sc, 5'd0, dc, 16'(so)};
    dw[2] = nb;
    dw[3] = sl;
    dw[4] = da;
    dw[5] = {1'b0, 6'd0, 9'(ci), 16'(dof)};
    dw[6] = dl;
    dw[7] = {1'b0, 6'd0, 9'(bi), 2'd0, 6'd0, 3'b000, sg, 1'b0, ih, im, go};
  endtask

  task automatic push();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); desc_we = 1'b1; desc_idx = 3'(i); desc_wdata = dw[i];
    end
    @(negedge clk); desc_we = 1'b0;
  endtask

  task automatic poke_desc(input logic [11:0] base);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); pk_en = 1'b1; pk_addr = base + 12'(4 * i); pk_data = dw[i];
      for (int k = 0; k < 4; k++) emem[12'(base + 12'(4 * i + k))] = dw[i][8*k +: 8];
    end
    @(negedge clk); pk_en = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (active && guard < 20000) begin @(negedge clk); guard++; end
  endtask

  task automatic run();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_idle();
  endtask

  // Byte-exact reference of the copy; s and d carry the running addresses.
  task automatic ref_run(inout int s, inout int d, input int so, input int dof, input int bb,
                         input int nb, input int iters, input int sl, input int dl, input bit sg);
    for (int it = 0; it < iters; it++)
      for (int b = 0; b < nb / bb; b++) begin
        for (int k = 0; k < bb; k++) emem[12'(d + k)] = emem[12'(s + k)];
        if (it == iters - 1 && b == nb / bb - 1) begin
          s = s + sl; if (!sg) d = d + dl;
        end else begin
          s = s + so; d = d + dof;
        end
      end
  endtask

  function automatic int bytes_of(input logic [2:0] c);
    case (c) 3'd0: return 1; 3'd1: return 2; 3'd2: return 4; 3'd4: return 16; default: return 32; endcase
  endfunction

  // ---------------- test sequence ----------------
  initial begin
    int s, d;
    logic [2:0] codes [0:4];
    void'($urandom(32'h5eed1234));
    codes[0] = 3'd0; codes[1] = 3'd1; codes[2] = 3'd2; codes[3] = 3'd4; codes[4] = 3'd5;
    for (int i = 0; i < 4096; i++) emem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", {active, done, irq_major, irq_half, err_valid, err_src_bus,
          err_dst_bus, err_off_cfg, err_cnt_cfg, mem_req}, 10'b0);

    // Directed: 4-byte beats, two outer iterations, both interrupts
    build(32'h100, 3'd2, 3'd2, 4, 32'd16, -32'sd32, 32'h900, 2, 4, 32'h40, 2, 0, 1, 1, 0);
    push();
    run();
    s = 'h100; d = 'h900;
    ref_run(s, d, 4, 4, 4, 16, 2, -32, 'h40, 0);
    check_mem("R4 inner loop copy 4B beats");
    check("R5 done after completion", {done, active}, 2'b10);
    check("R6 end interrupt", irq_major, 1'b1);
    check("R7 half interrupt", irq_half, 1'b1);
    // R5: restart without reload continues from adjusted addresses
    run();
    ref_run(s, d, 4, 4, 4, 16, 2, -32, 'h40, 0);
    check_mem("R5 restart uses end adjustments");
    check("R5 count reloaded, no error", err_valid, 1'b0);

    // Directed: 16-byte beats with negative source step
    build(32'h380, 3'd4, 3'd4, -16, 32'd48, 32'd0, 32'hA40, 1, 16, 32'd0, 1, 0, 0, 0, 0);
    push();
    run();
    s = 'h380; d = 'hA40;
    ref_run(s, d, -16, 16, 16, 48, 1, 0, 0, 0);
    check_mem("R3 16B beats negative step");
    check("R6 no end interrupt when disabled", irq_major, 1'b0);

    // Random descriptors
    for (int t = 0; t < 20; t++) begin
      logic [2:0] c;
      int bb, nb, it, so, dof;
      bit ih, im;
      c   = codes[$urandom % 5];
      bb  = bytes_of(c);
      nb  = bb * (1 + int'($urandom % 3));
      it  = 1 + int'($urandom % 3);
      so  = ($urandom % 2) ? bb : -bb;
      dof = ($urandom % 2) ? bb : -bb;
      ih  = 1'($urandom % 2);
      im  = 1'($urandom % 2);
      s   = 'h200 + (int'($urandom % 256) & ~(bb - 1));
      d   = 'hA00 + (int'($urandom % 256) & ~(bb - 1));
      build(32'(s), c, c, so, 32'(nb), 32'd0, 32'(d), it, dof, 32'd0, it, 0, ih, im, 0);
      push();
      run();
      ref_run(s, d, so, dof, bb, nb, it, 0, 0, 0);
      check_mem("R3 R4 random copy");
      check("R6 random end interrupt", irq_major, im);
      check("R7 random half interrupt", irq_half, ih && (it >= 2));
    end

    // R9 misaligned source address
    build(32'h102, 3'd2, 3'd2, 4, 32'd8, 32'd0, 32'h900, 1, 4, 32'd0, 1, 0, 0, 0, 0);
    push();
    run();
    check("R9 misaligned flags", {err_valid, err_off_cfg, err_cnt_cfg, active}, 4'b1100);
    check("R11 channel index reported", err_chan, 6'(CID));
    check_mem("R9 no memory written on config error");
    // R9 size mismatch
    build(32'h100, 3'd2, 3'd1, 4, 32'd8, 32'd0, 32'h900, 1, 2, 32'd0, 1, 0, 0, 0, 0);
    push();
    run();
    check("R9 size mismatch", {err_valid, err_off_cfg}, 2'b11);
    // R10 byte count not a multiple of the beat
    build(32'h100, 3'd2, 3'd2, 4, 32'd6, 32'd0, 32'h900, 1, 4, 32'd0, 1, 0, 0, 0, 0);
    push();
    run();
    check("R10 count not multiple", {err_valid, err_off_cfg, err_cnt_cfg}, 3'b101);
    // R10 current vs begin count mismatch
    build(32'h100, 3'd2, 3'd2, 4, 32'd8, 32'd0, 32'h900, 2, 4, 32'd0, 3, 0, 0, 0, 0);
    push();
    run();
    check("R10 count mismatch", {err_valid, err_cnt_cfg}, 2'b11);
    check_mem("R10 no memory written on config error");
    // R13 a good start clears stale flags
    build(32'h140, 3'd1, 3'd1, 2, 32'd4, 32'd0, 32'h940, 1, 2, 32'd0, 1, 0, 0, 0, 0);
    push();
    run();
    s = 'h140; d = 'h940;
    ref_run(s, d, 2, 2, 2, 4, 1, 0, 0, 0);
    check("R13 flags cleared on start", {err_valid, err_off_cfg, err_cnt_cfg, done}, 4'b0001);
    check_mem("R13 copy after error");

    // R11 read fault
    err_en = 1'b1; err_lo = 12'h300; err_hi = 12'h303;
    build(32'h2F8, 3'd2, 3'd2, 4, 32'd16, 32'd0, 32'hB80, 1, 4, 32'd0, 1, 0, 0, 0, 0);
    push();
    run();
    s = 'h2F8; d = 'hB80;
    ref_run(s, d, 4, 4, 4, 8, 1, 0, 0, 0);
    check("R11 read fault flags", {err_valid, err_src_bus, err_dst_bus, active, done}, 5'b11000);
    check("R11 read fault channel", err_chan, 6'(CID));
    check_mem("R11 copy stops at read fault");
    // R11 write fault
    err_lo = 12'hA04; err_hi = 12'hA07;
    build(32'h180, 3'd2, 3'd2, 4, 32'd16, 32'd0, 32'hA00, 1, 4, 32'd0, 1, 0, 0, 0, 0);
    push();
    run();
    s = 'h180; d = 'hA00;
    ref_run(s, d, 4, 4, 4, 4, 1, 0, 0, 0);
    check("R11 write fault flags", {err_valid, err_src_bus, err_dst_bus, active}, 4'b1010);
    check_mem("R11 copy stops at write fault");
    err_en = 1'b0;

    // R8 chain with go bit
    build(32'h400, 3'd1, 3'd1, 2, 32'd8, 32'd0, 32'hC00, 1, 2, 32'd0, 1, 0, 0, 1, 1);
    poke_desc(12'hF00);
    build(32'h1C0, 3'd2, 3'd2, 4, 32'd8, 32'd0, 32'hB00, 1, 4, 32'hF00, 1, 1, 0, 0, 0);
    push();
    run();
    s = 'h1C0; d = 'hB00;
    ref_run(s, d, 4, 4, 4, 8, 1, 0, 'hF00, 1);
    s = 'h400; d = 'hC00;
    ref_run(s, d, 2, 2, 2, 8, 1, 0, 0, 0);
    check_mem("R8 chained descriptor runs");
    check("R8 chain end state", {done, active, irq_major, err_valid}, 4'b1010);
    // R8 chain without go bit: stops, then start runs the loaded descriptor
    build(32'h480, 3'd0, 3'd0, 1, 32'd4, 32'd0, 32'hC80, 1, 1, 32'd0, 1, 0, 0, 0, 0);
    poke_desc(12'hF20);
    build(32'h1E0, 3'd2, 3'd2, 4, 32'd4, 32'd0, 32'hB40, 1, 4, 32'hF20, 1, 1, 0, 0, 0);
    push();
    run();
    s = 'h1E0; d = 'hB40;
    ref_run(s, d, 4, 4, 4, 4, 1, 0, 'hF20, 1);
    check_mem("R8 chain stops without go bit");
    check("R8 stopped chain state", {done, active}, 2'b10);
    run();
    s = 'h480; d = 'hC80;
    ref_run(s, d, 1, 1, 1, 4, 1, 0, 0, 0);
    check_mem("R8 loaded descriptor runs on start");

    // R2 / R13: descriptor write and start while active are ignored
    build(32'h500, 3'd0, 3'd0, 1, 32'd8, 32'd0, 32'hD00, 3, 1, 32'd0, 3, 0, 0, 0, 0);
    push();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    check("R13 engine busy mid transfer", active, 1'b1);
    desc_we = 1'b1; desc_idx = 3'd0; desc_wdata = 32'h050; start = 1'b1;
    @(negedge clk); desc_we = 1'b0; start = 1'b0;
    wait_idle();
    s = 'h500; d = 'hD00;
    ref_run(s, d, 1, 1, 1, 8, 3, 0, 0, 0);
    check_mem("R13 start while active ignored");
    run();
    ref_run(s, d, 1, 1, 1, 8, 3, 0, 0, 0);
    check_mem("R2 write while active ignored");

    check("R12 request held until response", 64'(hold_viol), 64'd0);
    check("R12 accesses aligned", 64'(align_viol), 64'd0);

    finished = 1;
    summary();
    $finish;
  end
endmodule